// File: doc/BRIEF.md
# CAM Register Interface

This block is the register front end of a content-addressable memory device. A 32-bit register port lets software reach five words: an indirect address pointer, a configuration word, a device-select word, a read-only status word and a read-only next-free word. The pointer drives the array's address lines and can step up or down, wrapping around the array depth. The configuration word drives the mask choice for direct writes, the control mode, the lowest-priority cascade marker and the page address.

The block does not contain the array. It drives address, mask and enable lines toward the array. It captures the array's match, multiple-match and full flags, the result kind and the result address whenever the array reports a new result. It packs those values, with the page address, into the status word. The next-free word packs the free address offered by the array with the page address. The device enable is high only when the software-written page field matches the configured page address and the active-low enable bit of the select word is 0.

Top module: `cam_csr`

## Requirements
- R1: After reset, the pointer, the configuration word and all status fields are 0, except that the three status flags read 1 (inactive) and the device-select word reads 0x0000_0100, so `dev_en` is 0.
- R2: A write to select 0 (pointer) stores `bus_wdata[12:0]`. A read of select 0 returns that value in bits 12:0 and 0 in bits 31:13.
- R3: With no pointer write, `step_op` = 01 increments the pointer and `step_op` = 10 decrements it, modulo DEPTH (8191 + 1 gives 0, and 0 − 1 gives 8191). Codes 00 and 11 hold the pointer.
- R4: When a pointer write and a step fall in the same cycle, the written value is stored and the step is dropped.
- R5: Select 1 (configuration) stores the following fields: bits 31:29 drive `mask_sel`, where 000 means unmasked; bits 27:26 drive `ctl_mode`; bit 25 drives `lowest_prio`; bits 3:0 drive `page_addr`. A read returns exactly these bits.
- R6: Select 2 (device select) stores bit 8 (disable, active high) and bits 3:0 (page). `dev_en` is 1 only when bit 8 is 0 and bits 3:0 equal `page_addr`.
- R7: Select 3 (status) reads as follows: bit 30 is the match flag, bit 29 the local multiple-match flag and bit 28 the full flag, all active low. Bits 25:24 hold the result kind (00 reset, 01 match, 10 memory access). Bits 19:16 hold `page_addr` and bits 12:0 hold the captured result address.
- R8: The status fields load from the `res_*` inputs only in a cycle where `res_valid` is 1. At all other times they hold their values.
- R9: Select 4 (next free) reads `page_addr` in bits 19:16 and `free_addr` in bits 12:0, with all other bits 0.
- R10: Reserved bits of every word read as 0. Writes to reserved bits, to selects 3 and 4, and to selects 5 to 7 change no state. Selects 5 to 7 read as 0.
- R11: `bus_rdata` shows the selected word one clock after the cycle in which `bus_rd` is 1, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| step_op | input | 2 | Pointer step: 01 increment, 10 decrement |
| res_valid | input | 1 | Array reports a new result |
| res_match_n | input | 1 | Match flag, active low |
| res_multi_n | input | 1 | Local multiple-match flag, active low |
| res_full_n | input | 1 | Full flag, active low |
| res_kind | input | 2 | Result kind code |
| res_addr | input | 13 | Result (active) address |
| free_addr | input | 13 | Next free address from the array |
| cam_addr | output | 13 | Pointer value toward the array |
| mask_sel | output | 3 | Mask choice for direct writes |
| ctl_mode | output | 2 | Control mode field |
| lowest_prio | output | 1 | Lowest-priority cascade marker |
| page_addr | output | 4 | Device page address |
| dev_en | output | 1 | Device enabled by software select |

## Verification
A pointer write from the register port and a step request from the control side can land in the same cycle, and they contend for the same register. The bench sets the pointer to the last entry, then raises `bus_wr` to select 0 together with `step_op` = 01 in one cycle. It then checks that `cam_addr` shows the written value and not the wrapped value 0. It then repeats the test with a decrement from 0, where the wrapped value would be 8191.

// File: rtl/cam_csr_pkg.sv
package cam_csr_pkg;

    localparam int WORD_W = 32;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_PTR  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CFG  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DSEL = 3'd2;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_FREE = 3'd4;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10,
        STEP_NONE = 2'b11
    } step_e;

    typedef struct packed {
        logic [2:0] mask_sel;
        logic [1:0] mode;
        logic       lowest;
        logic [3:0] page;
        logic       ds_off;
        logic [3:0] ds_page;
    } cfg_t;

endpackage

// File: rtl/cam_ptr_reg.sv
module cam_ptr_reg #(
    parameter int DEPTH  = 8192,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic [1:0]        step,
    output logic [ADDR_W-1:0] ptr
);
    import cam_csr_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] val;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) begin
            ptr_d.val = (wr_val > LAST) ? LAST : wr_val;
        end else begin
            case (step_e'(step))
                STEP_UP:   ptr_d.val = (ptr_q.val == LAST) ? '0 : ptr_q.val + 1'b1;
                STEP_DOWN: ptr_d.val = (ptr_q.val == '0) ? LAST : ptr_q.val - 1'b1;
                default:   ptr_d.val = ptr_q.val;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q.val;

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.val <= LAST); // R3
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val <= LAST) |=> ptr_q.val == $past(wr_val)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (step == 2'b00 || step == 2'b11)) |=> $stable(ptr_q.val)); // R3

endmodule

// File: rtl/cam_result_regs.sv
module cam_result_regs #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic              match_n,
    input  logic              multi_n,
    input  logic              full_n,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        flags_n,
    output logic [1:0]        kind_q_o,
    output logic [ADDR_W-1:0] addr_q_o
);

    typedef struct packed {
        logic [2:0]        flags_n;
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (res_valid) begin
            res_d.flags_n = {match_n, multi_n, full_n};
            res_d.kind    = kind;
            res_d.addr    = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '{flags_n: 3'b111, kind: 2'b00, addr: '0};
        else        res_q <= res_d;
    end

    assign flags_n  = res_q.flags_n;
    assign kind_q_o = res_q.kind;
    assign addr_q_o = res_q.addr;

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(res_q)); // R8
    AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> res_q.addr == $past(addr)); // R8

endmodule

// File: rtl/cam_csr.sv
module cam_csr #(
    parameter int DEPTH  = 8192,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_sel,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        step_op,
    input  logic              res_valid,
    input  logic              res_match_n,
    input  logic              res_multi_n,
    input  logic              res_full_n,
    input  logic [1:0]        res_kind,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic [ADDR_W-1:0] free_addr,
    output logic [ADDR_W-1:0] cam_addr,
    output logic [2:0]        mask_sel,
    output logic [1:0]        ctl_mode,
    output logic              lowest_prio,
    output logic [3:0]        page_addr,
    output logic              dev_en
);
    import cam_csr_pkg::*;

    typedef struct packed {
        cfg_t        cfg;
        logic [31:0] rdata;
    } top_t;

    top_t top_d, top_q;

    logic [2:0]        st_flags_n;
    logic [1:0]        st_kind;
    logic [ADDR_W-1:0] st_addr;
    logic              ptr_wr;

    assign ptr_wr = bus_wr && (bus_sel == SEL_PTR);

    cam_ptr_reg #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ptr_wr),
        .wr_val (bus_wdata[ADDR_W-1:0]),
        .step   (step_op),
        .ptr    (cam_addr)
    );

    cam_result_regs #(.ADDR_W(ADDR_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .match_n   (res_match_n),
        .multi_n   (res_multi_n),
        .full_n    (res_full_n),
        .kind      (res_kind),
        .addr      (res_addr),
        .flags_n   (st_flags_n),
        .kind_q_o  (st_kind),
        .addr_q_o  (st_addr)
    );

    logic [31:0] word_ptr, word_cfg, word_dsel, word_stat, word_free;

    always_comb begin
        word_ptr  = '0;
        word_ptr[ADDR_W-1:0] = cam_addr;
        word_cfg  = '0;
        word_cfg[31:29] = top_q.cfg.mask_sel;
        word_cfg[27:26] = top_q.cfg.mode;
        word_cfg[25]    = top_q.cfg.lowest;
        word_cfg[3:0]   = top_q.cfg.page;
        word_dsel = '0;
        word_dsel[8]    = top_q.cfg.ds_off;
        word_dsel[3:0]  = top_q.cfg.ds_page;
        word_stat = '0;
        word_stat[30:28] = st_flags_n;
        word_stat[25:24] = st_kind;
        word_stat[19:16] = top_q.cfg.page;
        word_stat[ADDR_W-1:0] = st_addr;
        word_free = '0;
        word_free[19:16] = top_q.cfg.page;
        word_free[ADDR_W-1:0] = free_addr;
    end

    always_comb begin
        top_d = top_q;
        if (bus_wr) begin
            case (bus_sel)
                SEL_CFG: begin
                    top_d.cfg.mask_sel = bus_wdata[31:29];
                    top_d.cfg.mode     = bus_wdata[27:26];
                    top_d.cfg.lowest   = bus_wdata[25];
                    top_d.cfg.page     = bus_wdata[3:0];
                end
                SEL_DSEL: begin
                    top_d.cfg.ds_off   = bus_wdata[8];
                    top_d.cfg.ds_page  = bus_wdata[3:0];
                end
                default: ;
            endcase
        end
        if (bus_rd) begin
            case (bus_sel)
                SEL_PTR:  top_d.rdata = word_ptr;
                SEL_CFG:  top_d.rdata = word_cfg;
                SEL_DSEL: top_d.rdata = word_dsel;
                SEL_STAT: top_d.rdata = word_stat;
                SEL_FREE: top_d.rdata = word_free;
                default:  top_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q         <= '0;
            top_q.cfg.ds_off <= 1'b1;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata   = top_q.rdata;
    assign mask_sel    = top_q.cfg.mask_sel;
    assign ctl_mode    = top_q.cfg.mode;
    assign lowest_prio = top_q.cfg.lowest;
    assign page_addr   = top_q.cfg.page;
    assign dev_en      = !top_q.cfg.ds_off && (top_q.cfg.ds_page == top_q.cfg.page);

    AST_EN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_en) |-> $past(bus_wr)); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[23:20] == 4'b0000); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11
    AST_CFG_NO_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel > 3'd2) |=> $stable(page_addr)); // R10

endmodule

// File: tb/cam_csr_bench.sv
module cam_csr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  step_op = 2'b00;
    logic        res_valid = 1'b0, res_match_n = 1'b1, res_multi_n = 1'b1, res_full_n = 1'b1;
    logic [1:0]  res_kind = 2'b00;
    logic [12:0] res_addr = '0;
    logic [12:0] free_addr = 13'h0ABC;
    logic [12:0] cam_addr;
    logic [2:0]  mask_sel;
    logic [1:0]  ctl_mode;
    logic        lowest_prio;
    logic [3:0]  page_addr;
    logic        dev_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cam_csr u_cam_csr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .step_op(step_op),
        .res_valid(res_valid), .res_match_n(res_match_n), .res_multi_n(res_multi_n),
        .res_full_n(res_full_n), .res_kind(res_kind), .res_addr(res_addr),
        .free_addr(free_addr), .cam_addr(cam_addr), .mask_sel(mask_sel),
        .ctl_mode(ctl_mode), .lowest_prio(lowest_prio), .page_addr(page_addr),
        .dev_en(dev_en)
    );

    // {is_write, sel, data, expected read}
    localparam int NV = 14;
    localparam logic [67:0] VEC [NV] = '{
        {1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 3'd0, 32'h0,         32'h0000_1FFF},
        {1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 3'd1, 32'h0,         32'hEE00_000F},
        {1'b1, 3'd2, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 3'd2, 32'h0,         32'h0000_010F},
        {1'b1, 3'd1, 32'h2000_0005, 32'h0},
        {1'b0, 3'd1, 32'h0,         32'h2000_0005},
        {1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 3'd3, 32'h0,         32'h7005_0000},
        {1'b0, 3'd4, 32'h0,         32'h0005_0ABC},
        {1'b0, 3'd5, 32'h0,         32'h0},
        {1'b1, 3'd0, 32'h0000_1234, 32'h0},
        {1'b0, 3'd0, 32'h0,         32'h0000_1234}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = sel;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 pointer", v, 32'h0);
        rd(3'd1, v); chk("R1 config", v, 32'h0);
        rd(3'd2, v); chk("R1 devsel", v, 32'h0000_0100);
        rd(3'd3, v); chk("R1 status", v, 32'h7000_0000);
        chk("R1 dev_en", {31'b0, dev_en}, 32'h0);

        // table: R2 R5 R6 R7 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][66:64], v);
                chk($sformatf("R2/R5/R6/R7/R9/R10 vector %0d", i), v, VEC[i][31:0]);
            end
        end

        // R5 outputs
        chk("R5 fields", {21'b0, mask_sel, ctl_mode, lowest_prio, page_addr},
            {21'b0, 3'd1, 2'd0, 1'b0, 4'd5});

        // R11 read data holds without a read
        repeat (3) @(negedge clk);
        chk("R11 hold", bus_rdata, 32'h0000_1234);

        // R6 device enable
        wr(3'd2, 32'h0000_0005); chk("R6 enable match", {31'b0, dev_en}, 32'h1);
        wr(3'd2, 32'h0000_0105); chk("R6 disable bit", {31'b0, dev_en}, 32'h0);
        wr(3'd2, 32'h0000_0004); chk("R6 page mismatch", {31'b0, dev_en}, 32'h0);

        // R3 stepping and wrap
        wr(3'd0, 32'h0000_1FFF);
        @(negedge clk); step_op = 2'b01; @(negedge clk); step_op = 2'b00;
        chk("R3 inc wrap", {19'b0, cam_addr}, 32'h0);
        @(negedge clk); step_op = 2'b10; @(negedge clk); step_op = 2'b00;
        chk("R3 dec wrap", {19'b0, cam_addr}, 32'h1FFF);
        @(negedge clk); step_op = 2'b11; @(negedge clk); step_op = 2'b00;
        chk("R3 code 11 hold", {19'b0, cam_addr}, 32'h1FFF);

        // R4 write beats step
        @(negedge clk); bus_wr = 1'b1; bus_sel = 3'd0; bus_wdata = 32'h0000_0100; step_op = 2'b01;
        @(negedge clk); bus_wr = 1'b0; step_op = 2'b00;
        chk("R4 write over inc", {19'b0, cam_addr}, 32'h0100);
        wr(3'd0, 32'h0);
        @(negedge clk); bus_wr = 1'b1; bus_sel = 3'd0; bus_wdata = 32'h0000_0000; step_op = 2'b10;
        @(negedge clk); bus_wr = 1'b0; step_op = 2'b00;
        chk("R4 write over dec", {19'b0, cam_addr}, 32'h0);

        // R7 R8 status capture
        @(negedge clk);
        res_valid = 1'b1; res_match_n = 1'b0; res_multi_n = 1'b1; res_full_n = 1'b0;
        res_kind = 2'b01; res_addr = 13'h0042;
        @(negedge clk);
        res_valid = 1'b0; res_match_n = 1'b1; res_full_n = 1'b1; res_kind = 2'b10; res_addr = 13'h1111;
        rd(3'd3, v); chk("R7 status packing", v, 32'h2105_0042);
        repeat (2) @(negedge clk);
        rd(3'd3, v); chk("R8 status held", v, 32'h2105_0042);

        // R9 next free follows input
        free_addr = 13'h1FFE;
        rd(3'd4, v); chk("R9 next free", v, 32'h0005_1FFE);

        done = 1'b1;
        finish_run();
    end

endmodule